// File: doc/BRIEF.md
# Rotating Windowed Register File

This block holds a configurable array of 32-bit physical registers. Sixteen of them are visible to the processor at any time, through a sliding window. A window base, counted in groups of four registers, selects where the window starts in the physical array. Logical register numbers 0 to 15 on three read ports and one write port are translated to physical indices as (base*4 + logical) mod NAREG. A window placed near the top of the array therefore continues at physical register 0.

The window base changes in two ways:

- **Relative rotation** adds a signed 4-bit delta.
- **Absolute set** loads a new value.

In both cases the result is reduced modulo the number of groups, NAREG/4. The current base is exported for neighbouring units. Reads are combinational. Writes and base changes take effect at the clock edge.

Top module: `winrf_top`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the window base output `wb_o` is 0.
- R2: Each read port returns, in the same cycle, the contents of physical register (wb_o*4 + address) mod NAREG.
- R3: When the window runs past physical register NAREG-1, the logical numbers beyond that point map to physical 0 upward. For example, with base NAREG/4-1, logical 4 reads physical 0.
- R4: A write with `wr_en_i` high stores `wr_data_i` at the clock edge into physical register (wb_o*4 + wr_addr_i) mod NAREG. From the next cycle on, the value is readable through any port that maps to that register.
- R5: With `rot_en_i` high and `wb_set_en_i` low, the next base is (wb_o + delta) mod NAREG/4. The delta `rot_delta_i` is a 4-bit two's-complement value from -8 to +7.
- R6: With `wb_set_en_i` high, the next base is `wb_set_val_i` mod NAREG/4. Bits of the set value above the base width have no effect.
- R7: When an absolute set and a relative rotation are requested in the same cycle, the absolute set wins and the rotation is discarded.
- R8: A write and a base change in the same cycle use the mapping from before the base change to place the write.
- R9: With neither request active, the base holds its value.
- R10: The three read ports are independent. Different addresses on all three ports return their own registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_addr_i | input | 4 | Logical register number, read port 0 |
| rd0_data_o | output | 32 | Read data, port 0 |
| rd1_addr_i | input | 4 | Logical register number, read port 1 |
| rd1_data_o | output | 32 | Read data, port 1 |
| rd2_addr_i | input | 4 | Logical register number, read port 2 |
| rd2_data_o | output | 32 | Read data, port 2 |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Logical register number for the write |
| wr_data_i | input | 32 | Write data |
| rot_en_i | input | 1 | Relative rotation request |
| rot_delta_i | input | 4 | Signed rotation amount |
| wb_set_en_i | input | 1 | Absolute base load request |
| wb_set_val_i | input | 8 | Value to load into the base (reduced modulo NAREG/4) |
| wb_o | output | log2(NAREG/4) | Current window base |

## Verification
Two pairs of functions can fall in the same cycle:

- a register write with a base change;
- an absolute set with a relative rotation.

Both pairs are provoked by directed cycles and by random stimulus, which raises all three enables independently. The bench keeps its own model of the physical array and of the base. It places each write using the base from before the edge, and it gives the absolute set priority. Every read port and the base output are then compared against that model on each cycle. A write placed with the rotated mapping, or a rotation that overrides a set, shows up as a miscompare.

// File: rtl/winrf_pkg.sv
`timescale 1ns/1ps
package winrf_pkg;
    localparam int unsigned LOG_REGS = 16;
    localparam int unsigned LOG_W    = 4;
    localparam int unsigned GRP_REGS = 4;

    typedef enum logic [1:0] {
        WB_HOLD = 2'd0,
        WB_ROT  = 2'd1,
        WB_SET  = 2'd2
    } wb_op_e;
endpackage

// File: rtl/winrf_map.sv
`timescale 1ns/1ps
module winrf_map #(
    parameter int unsigned NAREG = 64,
    localparam int unsigned IDX_W = $clog2(NAREG),
    localparam int unsigned WB_W  = $clog2(NAREG / 4)
) (
    input  logic [WB_W-1:0]               wb_i,
    input  logic [winrf_pkg::LOG_W-1:0]   log_i,
    output logic [IDX_W-1:0]              phys_o
);
    // Base*4 plus logical number; truncation to IDX_W gives the wrap.
    always_comb begin
        phys_o = IDX_W'({wb_i, 2'b00}) + IDX_W'(log_i);
    end

    // R3: a wrapped index keeps the position within its group of four
    always_comb begin
        map_low_bits_chk: assert (phys_o[1:0] == log_i[1:0]);
    end
endmodule

// File: rtl/winrf_base.sv
`timescale 1ns/1ps
module winrf_base #(
    parameter int unsigned NAREG  = 64,
    parameter int unsigned SETV_W = 8,
    localparam int unsigned NGRP  = NAREG / 4,
    localparam int unsigned WB_W  = $clog2(NGRP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rot_en_i,
    input  logic [3:0]        rot_delta_i,
    input  logic              set_en_i,
    input  logic [SETV_W-1:0] set_val_i,
    output logic [WB_W-1:0]   wb_o
);
    import winrf_pkg::*;

    typedef struct packed {
        logic [WB_W-1:0] wb;
    } state_t;

    state_t          st_d, st_q;
    wb_op_e          op;
    logic [WB_W-1:0] delta_ext;
    logic [WB_W-1:0] set_red;

    always_comb begin
        delta_ext = WB_W'($signed(rot_delta_i));
        set_red   = WB_W'(set_val_i % SETV_W'(NGRP));
        if (set_en_i)      op = WB_SET;
        else if (rot_en_i) op = WB_ROT;
        else               op = WB_HOLD;

        st_d = st_q;
        unique case (op)
            WB_SET:  st_d.wb = set_red;
            WB_ROT:  st_d.wb = st_q.wb + delta_ext;
            default: st_d.wb = st_q.wb;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_o = st_q.wb;

    // R1
    reset_base_zero_chk: assert property (@(posedge clk)
        !rst_n |=> wb_o == '0);

    // R5
    rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot_en_i && !set_en_i |=>
            wb_o == WB_W'($past(wb_o) + WB_W'($signed($past(rot_delta_i)))));

    // R6, R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> wb_o == WB_W'($past(set_val_i) % SETV_W'(NGRP)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rot_en_i && !set_en_i |=> $stable(wb_o));
endmodule

// File: rtl/winrf_top.sv
`timescale 1ns/1ps
module winrf_top #(
    parameter int unsigned NAREG  = 64,
    parameter int unsigned XLEN   = 32,
    parameter int unsigned SETV_W = 8,
    localparam int unsigned IDX_W = $clog2(NAREG),
    localparam int unsigned WB_W  = $clog2(NAREG / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd0_addr_i,
    output logic [XLEN-1:0]   rd0_data_o,
    input  logic [3:0]        rd1_addr_i,
    output logic [XLEN-1:0]   rd1_data_o,
    input  logic [3:0]        rd2_addr_i,
    output logic [XLEN-1:0]   rd2_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_addr_i,
    input  logic [XLEN-1:0]   wr_data_i,
    input  logic              rot_en_i,
    input  logic [3:0]        rot_delta_i,
    input  logic              wb_set_en_i,
    input  logic [SETV_W-1:0] wb_set_val_i,
    output logic [WB_W-1:0]   wb_o
);
    localparam int unsigned NRD = 3;

    logic [WB_W-1:0]  wb;
    logic [3:0]       rd_addr [NRD];
    logic [XLEN-1:0]  rd_data [NRD];
    logic [IDX_W-1:0] rd_phys [NRD];
    logic [IDX_W-1:0] wr_phys;
    logic [XLEN-1:0]  regs_q  [NAREG];

    initial begin
        if (NAREG < 32 || (NAREG & (NAREG - 1)) != 0)
            $error("NAREG must be a power of two and at least 32");
    end

    winrf_base #(.NAREG(NAREG), .SETV_W(SETV_W)) u_base (
        .clk         (clk),
        .rst_n       (rst_n),
        .rot_en_i    (rot_en_i),
        .rot_delta_i (rot_delta_i),
        .set_en_i    (wb_set_en_i),
        .set_val_i   (wb_set_val_i),
        .wb_o        (wb)
    );

    assign rd_addr[0] = rd0_addr_i;
    assign rd_addr[1] = rd1_addr_i;
    assign rd_addr[2] = rd2_addr_i;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        winrf_map #(.NAREG(NAREG)) u_map (
            .wb_i   (wb),
            .log_i  (rd_addr[p]),
            .phys_o (rd_phys[p])
        );
        assign rd_data[p] = regs_q[rd_phys[p]];
    end

    // Write placed with the base held before this edge (pre-rotation).
    winrf_map #(.NAREG(NAREG)) u_wmap (
        .wb_i   (wb),
        .log_i  (wr_addr_i),
        .phys_o (wr_phys)
    );

    // Contents are not reset.
    always_ff @(posedge clk) begin
        if (wr_en_i) regs_q[wr_phys] <= wr_data_i;
    end

    assign rd0_data_o = rd_data[0];
    assign rd1_data_o = rd_data[1];
    assign rd2_data_o = rd_data[2];
    assign wb_o       = wb;

    // R4
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !rot_en_i && !wb_set_en_i |=>
            (rd0_addr_i != $past(wr_addr_i) || rd0_data_o == $past(wr_data_i)));

    // R8
    write_prerot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> regs_q[$past(wr_phys)] == $past(wr_data_i));
endmodule

// File: tb/tb_winrf_top.sv
`timescale 1ns/1ps
module tb_winrf_top;
    localparam int NAREG = 64;
    localparam int NGRP  = NAREG / 4;
    localparam int WB_W  = $clog2(NGRP);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        a0 = '0, a1 = '0, a2 = '0;
    logic [31:0]       d0, d1, d2;
    logic              we = 1'b0;
    logic [3:0]        wa = '0;
    logic [31:0]       wd = '0;
    logic              re = 1'b0;
    logic [3:0]        rd = '0;
    logic              se = 1'b0;
    logic [7:0]        sv = '0;
    logic [WB_W-1:0]   wb;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 0;

    logic [31:0] model [NAREG];
    bit          known [NAREG];
    int          wb_m = 0;

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    winrf_top #(.NAREG(NAREG)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_addr_i(a0), .rd0_data_o(d0),
        .rd1_addr_i(a1), .rd1_data_o(d1),
        .rd2_addr_i(a2), .rd2_data_o(d2),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
        .rot_en_i(re), .rot_delta_i(rd),
        .wb_set_en_i(se), .wb_set_val_i(sv),
        .wb_o(wb)
    );

    function automatic int phys(input int base, input int l);
        return (base * 4 + l) % NAREG;
    endfunction

    function automatic int sext4(input logic [3:0] v);
        return v[3] ? int'(v) - 16 : int'(v);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [3:0] a, input logic [31:0] act);
        int p = phys(wb_m, int'(a));
        if (known[p]) chk(tag, act, model[p]);
    endtask

    // One cycle: drive at negedge, check combinational outputs, clock, update model.
    task automatic cyc(input string tag,
                       input logic i_we, input logic [3:0] i_wa, input logic [31:0] i_wd,
                       input logic i_re, input logic [3:0] i_rd,
                       input logic i_se, input logic [7:0] i_sv,
                       input logic [3:0] i_a0, input logic [3:0] i_a1, input logic [3:0] i_a2);
        we = i_we; wa = i_wa; wd = i_wd; re = i_re; rd = i_rd;
        se = i_se; sv = i_sv; a0 = i_a0; a1 = i_a1; a2 = i_a2;
        #1;
        chk({tag, " base"}, 32'(wb), 32'(wb_m));
        chk_rd({tag, " port0"}, i_a0, d0);
        chk_rd({tag, " port1"}, i_a1, d1);
        chk_rd({tag, " port2"}, i_a2, d2);
        @(posedge clk);
        if (i_we) begin
            model[phys(wb_m, int'(i_wa))] = i_wd;
            known[phys(wb_m, int'(i_wa))] = 1;
        end
        if (i_se)      wb_m = int'(i_sv) % NGRP;
        else if (i_re) wb_m = (wb_m + sext4(i_rd) + NGRP) % NGRP;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        for (int i = 0; i < NAREG; i++) known[i] = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 base in reset", 32'(wb), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 base after release", 32'(wb), 32'd0);
        @(negedge clk);

        // Fill the whole physical array, one window of 16 at a time (R4).
        for (int g = 0; g < NAREG / 16; g++) begin
            cyc("R6", 0, 0, 0, 0, 0, 1, 8'(g * 4), 0, 1, 2);
            for (int l = 0; l < 16; l++)
                cyc("R4", 1, 4'(l), $urandom, 0, 0, 0, 0, 4'(l), 0, 15);
        end

        // R3: window straddling the top of the array.
        cyc("R6", 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);         // masks to NGRP-1
        cyc("R3", 0, 0, 0, 0, 0, 0, 0, 4, 15, 3);            // phys 0, 11, 63
        cyc("R3", 1, 5, 32'hCAFE0005, 0, 0, 0, 0, 5, 6, 7);  // write phys 1
        cyc("R3", 0, 0, 0, 0, 0, 0, 0, 5, 4, 12);
        // R10: three different registers at once.
        cyc("R10", 0, 0, 0, 0, 0, 0, 0, 1, 8, 14);
        // R5: negative rotation wrapping below zero.
        cyc("R6", 0, 0, 0, 0, 0, 1, 8'd0, 0, 0, 0);
        cyc("R5", 0, 0, 0, 1, 4'hD, 0, 0, 0, 0, 0);          // -3 -> NGRP-3
        cyc("R5", 0, 0, 0, 1, 4'h7, 0, 0, 2, 3, 4);          // +7 wraps
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 9, 10, 11);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: upper set bits ignored.
        cyc("R6", 0, 0, 0, 0, 0, 1, 8'h47, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R7: set and rotation together.
        cyc("R7", 0, 0, 0, 1, 4'h5, 1, 8'd2, 0, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: write with rotation in the same cycle, then read it back.
        cyc("R8", 0, 0, 0, 0, 0, 1, 8'd3, 0, 0, 0);
        cyc("R8", 1, 2, 32'hBEEF0014, 1, 4'hF, 0, 0, 0, 0, 0); // phys 14, base -> 2
        cyc("R8", 0, 0, 0, 0, 0, 0, 0, 6, 5, 7);               // logical 6 = phys 14
        cyc("R8", 1, 9, 32'h0BAD0009, 0, 0, 1, 8'd10, 0, 0, 0);
        cyc("R8", 0, 0, 0, 0, 0, 0, 0, 9, 1, 2);

        // Random traffic covering R2, R4, R5, R6, R7, R8, R10.
        for (int n = 0; n < 1500; n++) begin
            cyc("R2/R4/R5/R6/R7/R8/R10",
                ($urandom % 2) == 0, 4'($urandom), $urandom,
                ($urandom % 3) == 0, 4'($urandom),
                ($urandom % 5) == 0, 8'($urandom),
                4'($urandom), 4'($urandom), 4'($urandom));
        end
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
        finish_run();
    end
endmodule